// File: doc/BRIEF.md
# Shift register with input storage

This block is a parallel-to-serial converter with a holding stage in front of it. A storage register samples the parallel data bus on its own clock. A shift register, on a separate shift clock, either takes over the stored word or moves bits in from a serial input. The shift register's last stage drives the only output.

Taking over the stored word is asynchronous. When the active-low load input falls, the stored word is copied into the shift register at once, with no shift clock edge needed. A producer can therefore capture a word whenever its data is ready, and hand it to the serial side at any phase of the shift clock. An active-low reset clears the shift register at any time. It leaves the stored word intact, so the same word can be sent again after a reset.

Top module: `piso_store_shift`

## Requirements
- R1: On each rising edge of `st_clk`, the storage register samples `d`. The sampled word reaches `ser_out` only through a load.
- R2: When `load_n` falls while `rst_n` is high, the shift register takes the storage contents at once, and `ser_out` shows storage bit 7 before any shift clock edge.
- R3: While `load_n` is low, rising edges of `sh_clk` do not shift. Each such edge reloads the current storage contents, so a word captured during the low period is taken in at the next shift clock edge.
- R4: While `load_n` is high, each rising edge of `sh_clk` moves `ser_in` into stage 0 and moves stage i into stage i+1.
- R5: `ser_out` is stage 7. After a load, the loaded word leaves bit 7 first and bit 0 last, one bit per shift edge.
- R6: A low on `rst_n` clears the shift register at once, without a clock edge, and `ser_out` reads 0.
- R7: When `rst_n` and `load_n` are both low, reset wins and the shift register stays all zeros.
- R8: Reset does not change the storage register. A load after reset delivers the word stored before the reset.
- R9: A storage capture while `load_n` is high does not disturb the bits being shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| st_clk | input | 1 | Storage clock; rising edge samples `d` |
| sh_clk | input | 1 | Shift clock; rising edge shifts or reloads |
| rst_n | input | 1 | Active-low asynchronous clear of the shift register |
| load_n | input | 1 | Active-low asynchronous transfer from storage to shift register |
| d | input | 8 | Parallel data word |
| ser_in | input | 1 | Serial data into stage 0 |
| ser_out | output | 1 | Serial data from stage 7 |

## Verification
Only one bit of the shift register is visible at a time, so a bad stage usually stays hidden until it reaches stage 7. That can take up to seven shift edges after the fault. For this reason every directed scenario reads whole words out serially, not single bits. A storage register that captured wrongly shows nothing at the output until the next load exposes bit 7 at once, and the rest of the word follows over the next seven edges. Faults in reset or load priority show at the pin immediately, in the same cycle, because both inputs act without a clock.

// File: rtl/piso_store_shift.sv
`timescale 1ns/1ps
module piso_store_shift #(
  parameter int W = 8
) (
  input  logic         st_clk,
  input  logic         sh_clk,
  input  logic         rst_n,
  input  logic         load_n,
  input  logic [W-1:0] d,
  input  logic         ser_in,
  output logic         ser_out
);
  localparam int MSB = W - 1;

  logic [W-1:0] stor_q;
  logic [W-1:0] shift_q;

  always_ff @(posedge st_clk)
    stor_q <= d;

  always_ff @(posedge sh_clk or negedge rst_n or negedge load_n)
    if (!rst_n)
      shift_q <= '0;
    else if (!load_n)
      shift_q <= stor_q;
    else
      shift_q <= {shift_q[MSB-1:0], ser_in};

  assign ser_out = shift_q[MSB];
endmodule

// File: rtl/piso_store_shift_chk.sv
`timescale 1ns/1ps
module piso_store_shift_chk #(
  parameter int W = 8
) (
  input logic         sh_clk,
  input logic         rst_n,
  input logic         load_n,
  input logic         ser_in,
  input logic [W-1:0] stor,
  input logic [W-1:0] sh,
  input logic         ser_out
);
  logic evt;

  always_ff @(posedge sh_clk or negedge load_n or negedge rst_n)
    if (!load_n || !rst_n)
      evt <= 1'b1;
    else
      evt <= 1'b0;

  // R6 R7
  always @(negedge sh_clk)
    if (!rst_n)
      reset_clear_chk: assert (sh == '0 && ser_out == 1'b0);

  // R2
  async_load_chk: assert property (@(posedge sh_clk) disable iff (!rst_n)
    (!load_n && $past(rst_n) && $stable(stor)) |-> sh == stor);

  // R3
  load_refresh_chk: assert property (@(posedge sh_clk) disable iff (!rst_n)
    (!$past(load_n) && $past(rst_n)) |-> sh == $past(stor));

  // R4
  shift_step_chk: assert property (@(posedge sh_clk) disable iff (!rst_n)
    (load_n && !evt) |-> sh == {$past(sh[W-2:0]), $past(ser_in)});
endmodule

bind piso_store_shift piso_store_shift_chk #(.W(W)) u_chk (
  .sh_clk(sh_clk), .rst_n(rst_n), .load_n(load_n), .ser_in(ser_in),
  .stor(stor_q), .sh(shift_q), .ser_out(ser_out)
);

// File: tb/piso_store_shift_tb.sv
`timescale 1ns/1ps
module piso_store_shift_tb;
  logic st_clk = 0, sh_clk = 0, rst_n = 0, load_n = 1, ser_in = 0;
  logic [7:0] d = '0;
  logic ser_out;
  int n_run = 0, n_fail = 0;
  logic [7:0] m_stor, m_sh;

  piso_store_shift u_dut (.st_clk(st_clk), .sh_clk(sh_clk), .rst_n(rst_n),
    .load_n(load_n), .d(d), .ser_in(ser_in), .ser_out(ser_out));

  always #2 sh_clk = ~sh_clk;

  task automatic chk(input logic exp, input string tag);
    n_run++;
    if (ser_out !== exp) begin
      n_fail++;
      $display("FAIL %s: ser_out=%0b expected %0b", tag, ser_out, exp);
    end
  endtask

  task automatic finish_cycle(input string tag);
    @(posedge sh_clk);
    if (!rst_n) m_sh = '0;
    else if (!load_n) m_sh = m_stor;
    else m_sh = {m_sh[6:0], ser_in};
    @(negedge sh_clk);
    chk(m_sh[7], tag);
  endtask

  task automatic tick(input logic b, input string tag);
    ser_in = b;
    finish_cycle(tag);
  endtask

  task automatic store(input logic [7:0] v, input string tag);
    #0.5 d = v;
    #0.5 st_clk = 1; m_stor = v;
    #0.5 st_clk = 0;
    finish_cycle(tag);
  endtask

  task automatic load_pulse(input string tag);
    #0.5 load_n = 0;
    #0.5 m_sh = m_stor;
    chk(m_stor[7], tag);
    #0.5 load_n = 1;
  endtask

  task automatic readout(input logic [7:0] w, input string tag);
    load_pulse({tag, " R2 first bit"});
    for (int i = 6; i >= 0; i--) begin
      tick(1'b0, {tag, " R5 readout"});
      n_run++;
      if (ser_out !== w[i]) begin
        n_fail++;
        $display("FAIL R5 %s: bit %0d ser_out=%0b expected %0b", tag, i, ser_out, w[i]);
      end
    end
    tick(1'b0, {tag, " R4 drain"});
  endtask

  task automatic t_reset;
    repeat (2) @(negedge sh_clk);
    chk(1'b0, "R6 reset state");
    rst_n = 1;
    m_sh = '0;
    @(negedge sh_clk);
  endtask

  task automatic t_load_readout;
    store(8'hA5, "R1 capture");
    readout(8'hA5, "A5");
    store(8'h3C, "R1 capture");
    readout(8'h3C, "3C");
  endtask

  task automatic t_serial;
    logic [7:0] p = 8'b1100_1010;
    for (int i = 7; i >= 0; i--) tick(p[i], "R4 shift in");
    for (int i = 7; i >= 0; i--) begin
      n_run++;
      if (ser_out !== p[i]) begin
        n_fail++;
        $display("FAIL R4: serial bit %0d ser_out=%0b expected %0b", i, ser_out, p[i]);
      end
      tick(1'b1, "R4 shift out");
    end
  endtask

  task automatic t_store_while_shifting;
    store(8'hF0, "R1 capture");
    load_pulse("R2 load F0");
    tick(1'b0, "R5 F0 bit6");
    store(8'h0F, "R9 capture during shift");
    tick(1'b0, "R9 F0 bit4");
    tick(1'b0, "R9 F0 bit3");
    readout(8'h0F, "0F R1");
  endtask

  task automatic t_reset_mid_shift;
    store(8'hFF, "R1 capture");
    load_pulse("R2 load FF");
    tick(1'b1, "R5 FF");
    tick(1'b1, "R5 FF");
    #0.5 rst_n = 0;
    #0.5 m_sh = '0;
    chk(1'b0, "R6 async clear");
    #0.5 rst_n = 1;
    finish_cycle("R6 after clear");
    for (int i = 0; i < 6; i++) tick(1'b0, "R6 zeros after clear");
    readout(8'hFF, "FF R8");
  endtask

  task automatic t_priority;
    store(8'h81, "R1 capture");
    rst_n = 0; m_sh = '0;
    #0.5 load_n = 0;
    #0.5 chk(1'b0, "R7 reset beats load");
    finish_cycle("R7 edge both low");
    rst_n = 1;
    #0.5 chk(1'b0, "R7 no load on reset release");
    finish_cycle("R3 reload after release");
    load_n = 1;
    for (int i = 0; i < 7; i++) tick(1'b0, "R5 81 readout");
  endtask

  task automatic t_hold;
    store(8'hC3, "R1 capture");
    load_n = 0; m_sh = m_stor;
    #0.5 chk(1'b1, "R2 load held");
    for (int i = 0; i < 4; i++) tick(i[0], "R3 hold while load low");
    store(8'h44, "R3 refresh from new capture");
    tick(1'b1, "R3 hold new word");
    load_n = 1;
    for (int i = 0; i < 8; i++) tick(1'b0, "R4 release shifts");
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge sh_clk);
    t_reset;
    t_load_readout;
    t_serial;
    t_store_while_shifting;
    t_reset_mid_shift;
    t_priority;
    t_hold;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule